// File: doc/BRIEF.md
# Multichannel DAC Command Word Decoder

This block takes 16-bit command words from a parallel bus, each one qualified by a write strobe. It steers each word into one of eight channel registers, and each register drives one downstream converter. A word has three fields: a 12-bit unsigned conversion code, a 3-bit binary channel address, and one enable bit that applies to the whole block. Each register is presented as a parallel code output. Code 0 is the bottom of the converter scale and 4095 is full scale, with a linear relation between them.

Clearing the enable bit wipes every channel register, so all outputs fall to code 0. Setting the enable bit again does not bring the old values back. Each channel stays at 0 until a word addressed to it arrives. Every channel also has a busy flag. It stays high for a fixed, parameterised number of cycles after that channel is written, which models the converter's settling time. Software may write channels in any order, and may write them back to back.

Top module: `dacw_top`

## Requirements
- R1: After synchronous reset, all eight code outputs are 0, all busy flags are 0, and the block is disabled.
- R2: Word fields: bits 11..0 carry the code. Bits 14..12 carry the channel address, where value k selects channel k, so 000 is the first channel and 111 is the eighth. Bit 15 is the global enable.
- R3: A strobed word with bit 15 = 1 loads its code into the addressed channel only. The new value appears on that channel's output after the sampling clock edge.
- R4: A strobed word with bit 15 = 0 clears all eight codes to 0 after the sampling edge. It loads no channel, whatever its channel and code fields hold.
- R5: After a disable, a word with bit 15 = 1 re-enables the block and loads only its own channel. Every other channel stays at 0 until it is written.
- R6: Writes on consecutive cycles, to channels in any order, each land in their own channel.
- R7: When the strobe is low, no output changes, whatever is on the word bus.
- R8: The busy flag of a channel is 1 for exactly SETTLE_CYC cycles after an enabled write to that channel. No other channel's flag is affected.
- R9: An enabled write to a channel whose flag is already set restarts its full SETTLE_CYC window.
- R10: A disabling word clears every busy flag after its sampling edge.
- R11: Codes 0 and 4095 pass to the output unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe; samples wr_word on the rising edge |
| wr_word | input | 16 | Command word: enable, channel address, code |
| code_o | output | 96 | Eight 12-bit codes; channel k occupies bits 12k+11..12k |
| busy_o | output | 8 | Per-channel settling flags; bit k is channel k |

## Verification
A corrupted channel register shows on its code output one cycle after the sampling edge, because every output comes straight from a register. A wrong enable state is seen by the effect it has. A write that lands while the block should be disabled, or a clear that leaves stale data behind, shows on the next cycle. A counter that is off by one moves the falling edge of a busy flag by exactly one cycle. A flag raised on the wrong channel appears on the cycle after the write. Checking every output on every cycle exposes each of these faults within one or two cycles of its cause.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 12;
  localparam int SEL_W  = 3;
  localparam int SEL_LSB = CODE_W;
  localparam int EN_BIT  = SEL_LSB + SEL_W;

  typedef struct packed {
    logic              en;
    logic [SEL_W-1:0]  sel;
    logic [CODE_W-1:0] code;
  } cmd_t;
endpackage

// File: rtl/dacw_decode.sv
module dacw_decode
  import dacw_pkg::*;
#(
  parameter int NUM_CH = 1 << SEL_W
) (
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_word,
  output logic [CODE_W-1:0] code,
  output logic [NUM_CH-1:0] load_vec,
  output logic              clr,
  output logic              set_en
);
  cmd_t cmd;

  always_comb begin
    cmd      = cmd_t'(wr_word);
    code     = cmd.code;
    clr      = wr_stb && !cmd.en;
    set_en   = wr_stb && cmd.en;
    load_vec = '0;
    if (set_en) load_vec[cmd.sel] = 1'b1;
  end
endmodule

// File: rtl/dacw_channel.sv
module dacw_channel #(
  parameter int DATA_W     = 12,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] code_q,
  output logic              busy
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code_q <= '0;
      cnt    <= '0;
    end else if (load) begin
      code_q <= din;
      cnt    <= CNT_INIT;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/dacw_top.sv
module dacw_top
  import dacw_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int NUM_CH     = 1 << SEL_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_stb,
  input  logic [WORD_W-1:0]        wr_word,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        busy_o
);
  logic [CODE_W-1:0] dec_code;
  logic [NUM_CH-1:0] load_vec;
  logic              clr;
  logic              set_en;
  logic              en_q;

  dacw_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr_stb  (wr_stb),
    .wr_word (wr_word),
    .code    (dec_code),
    .load_vec(load_vec),
    .clr     (clr),
    .set_en  (set_en)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) en_q <= 1'b0;
    else if (set_en) en_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dacw_channel #(.DATA_W(CODE_W), .SETTLE_CYC(SETTLE_CYC)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .load  (load_vec[g]),
      .din   (dec_code),
      .code_q(code_o[g*CODE_W +: CODE_W]),
      .busy  (busy_o[g])
    );
  end
endmodule

// File: rtl/dacw_chk.sv
module dacw_chk
  import dacw_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_stb,
  input logic [WORD_W-1:0]        wr_word,
  input logic [NUM_CH*CODE_W-1:0] code_o,
  input logic [NUM_CH-1:0]        busy_o,
  input logic                     en_q
);
  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_o == '0 && busy_o == '0 && !en_q));

  p_disable_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !wr_word[EN_BIT]) |=> (code_o == '0 && busy_o == '0));

  p_disabled_min_r4: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (code_o == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(code_o));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && wr_word[EN_BIT] && wr_word[EN_BIT-1:SEL_LSB] == SEL_W'(i))
      |=> (code_o[i*CODE_W +: CODE_W] == $past(wr_word[CODE_W-1:0]) && busy_o[i]));

    p_busy_cause_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o[i]) |-> $past(wr_stb && wr_word[EN_BIT]
                                  && wr_word[EN_BIT-1:SEL_LSB] == SEL_W'(i)));
  end
endmodule

bind dacw_top dacw_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_stb (wr_stb),
  .wr_word(wr_word),
  .code_o (code_o),
  .busy_o (busy_o),
  .en_q   (en_q)
);

// File: tb/tb_dacw_top.sv
module tb_dacw_top;
  localparam int SETTLE = 4;
  localparam int NCH = 8;
  localparam int CW = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_stb = 1'b0;
  logic [15:0]       wr_word = '0;
  logic [NCH*CW-1:0] code_o;
  logic [NCH-1:0]    busy_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int exp_code [NCH];
  int exp_cnt  [NCH];

  always #5 clk = ~clk;

  dacw_top #(.SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_word(wr_word),
    .code_o(code_o), .busy_o(busy_o)
  );

  function automatic logic [15:0] mkw(bit en, int ch, int code);
    return {en, 3'(ch), 12'(code)};
  endfunction

  task automatic check_all(string tag);
    for (int c = 0; c < NCH; c++) begin
      int act_code = int'(code_o[c*CW +: CW]);
      int act_busy = int'(busy_o[c]);
      int eb = (exp_cnt[c] > 0) ? 1 : 0;
      checks++;
      if (act_code != exp_code[c] || act_busy != eb) begin
        errors++;
        $display("FAIL %s ch%0d: code=%0d busy=%0d expected code=%0d busy=%0d",
                 tag, c, act_code, act_busy, exp_code[c], eb);
      end
    end
  endtask

  // Drive at negedge, model after posedge, check at next negedge.
  task automatic step(bit stb, logic [15:0] w, string tag);
    wr_stb  = stb;
    wr_word = w;
    @(posedge clk);
    for (int c = 0; c < NCH; c++) if (exp_cnt[c] > 0) exp_cnt[c]--;
    if (stb) begin
      if (!w[15]) begin
        for (int c = 0; c < NCH; c++) begin
          exp_code[c] = 0;
          exp_cnt[c]  = 0;
        end
      end else begin
        exp_code[w[14:12]] = int'(w[11:0]);
        exp_cnt[w[14:12]]  = SETTLE;
      end
    end
    @(negedge clk);
    wr_stb = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      exp_code[c] = 0;
      exp_cnt[c]  = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    // R7: garbage on bus without strobe
    step(1'b0, 16'hFFFF, "R7 idle no strobe");
    step(1'b0, 16'h7ABC, "R7 idle no strobe");

    // R2/R3: each channel in ascending order, distinct codes
    for (int c = 0; c < NCH; c++) step(1'b1, mkw(1, c, c * 511 + 7), "R2 R3 load");
    repeat (SETTLE + 1) step(1'b0, 16'h1234, "R8 busy decay");

    // R11: extremes
    step(1'b1, mkw(1, 0, 0), "R11 zero");
    step(1'b1, mkw(1, 7, 4095), "R11 full");
    step(1'b1, mkw(1, 3, 4095), "R11 full");

    // R6: sweep codes, back to back, forward and reverse
    for (int v = 0; v < 4096; v += 273) begin
      for (int c = 0; c < NCH; c++) step(1'b1, mkw(1, c, (v + c * 37) % 4096), "R6 fwd");
      for (int c = NCH - 1; c >= 0; c--) step(1'b1, mkw(1, c, 4095 - ((v + c) % 4096)), "R6 rev");
    end
    repeat (SETTLE + 1) step(1'b0, '0, "R7 hold");

    // R8: single-channel window
    step(1'b1, mkw(1, 3, 1000), "R8 single");
    repeat (SETTLE + 2) step(1'b0, mkw(1, 5, 55), "R8 window");

    // R9: restart while busy
    step(1'b1, mkw(1, 2, 222), "R9 first");
    step(1'b0, '0, "R9 gap");
    step(1'b0, '0, "R9 gap");
    step(1'b1, mkw(1, 2, 333), "R9 rewrite");
    repeat (SETTLE + 1) step(1'b0, '0, "R9 window");

    // R4/R10: disable while busy, nonzero channel/code fields
    step(1'b1, mkw(1, 4, 444), "R10 pre");
    step(1'b0, '0, "R10 gap");
    step(1'b1, mkw(0, 5, 12'hABC), "R4 R10 disable");
    step(1'b0, '0, "R4 after");

    // R5: re-enable writes only its own channel
    step(1'b1, mkw(1, 5, 100), "R5 reenable");
    repeat (3) step(1'b0, 16'hFFFF, "R5 others zero");
    step(1'b1, mkw(1, 1, 4095), "R5 second");

    // R4: every channel field while disabled leaves zero
    for (int c = 0; c < NCH; c++) step(1'b1, mkw(0, c, 4095 - c), "R4 sweep");
    repeat (2) step(1'b0, '0, "R4 hold");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule